// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Interface

This block is the digital front end of a two-channel 14-bit converter. A three-wire serial port (active-low chip select, serial clock, serial data) fills a 16-bit shift register. When chip select returns high, the most recent 16 bits form a word: a two-bit channel mask and a 14-bit code. The code is written into the input register of each selected channel. Behind the input registers sits a second rank, the converter registers, which drive the outputs. They follow the input registers while an active-low load strobe is held low and keep their value while it is high. Both channels can therefore be staged one after the other and changed together.

The serial pins and the load strobe are asynchronous to the block. They are brought into the system clock domain through synchronizers, and serial clock and chip select edges are found on the synchronized copies. The system clock must run at least four times faster than the serial clock. A synchronous power-on reset and an asynchronous active-low clear preset every input and converter register. A select pin chooses the preset value: zero scale or half scale.

Top module: `dual_dac_regs`

## Requirements
- R1: A frame is shifted in most significant bit first. Of the committed 16-bit word, bits [13:0] are the code and bits [15:14] are the channel mask.
- R2: A bit is taken only on a rising serial clock edge while chip select is low. Serial clock activity while chip select is high changes no register.
- R3: On the rising edge of chip select, only the last 16 bits shifted in are used. Earlier bits of a longer frame, such as the first byte of a 24-bit frame, are discarded. Each chip select rise commits at most one word.
- R4: A frame of fewer than 16 bits since chip select fell leaves every register unchanged.
- R5: Mask 2'b01 writes channel A only, 2'b10 channel B only, 2'b11 both, and 2'b00 neither. An input register changes only on a commit that selects it, or on reset.
- R6: While the load strobe is low, each converter register follows its input register. While the strobe is high, the converter registers hold.
- R7: While the clear input is low, all input and converter registers are held at the preset value at once, without waiting for a clock edge. The clear overrides serial commits and the load strobe.
- R8: The power-on reset sets all input and converter registers to the preset value, and they keep it until a serial load and strobe change them.
- R9: The preset value is 14'h0000 when the preset select is 0 and 14'h2000 when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear to the preset value |
| half_sel | input | 1 | Preset select: 0 gives zero scale, 1 gives half scale |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low, level-sensitive load strobe for the converter registers |
| dac_code | output | 28 | Converter register values; channel A in [13:0], channel B in [27:14] |

## Verification
The bench uses the default build: two channels, 14-bit codes, a 16-bit frame and two synchronizer stages. With these values, every mask code and both preset values (0x0000 and 0x2000) can be checked directly at the output bus. The 16-bit frame lets 10-bit, 16-bit and 24-bit transfers exercise the short-frame rule and the keep-the-last-16-bits rule. Random frames of random length and mask, sent with the strobe held low, are checked against a reference model. Directed cases then cover strobe hold, clocking with chip select high, and clear and reset with each preset select value.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

    // Code width per channel and number of channels (one mask bit per channel)
    localparam int DAC_W   = 14;
    localparam int NUM_CH  = 2;
    localparam int FRAME_W = NUM_CH + DAC_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    // Committed word: channel mask on top, code below
    typedef struct packed {
        logic [NUM_CH-1:0] sel;
        logic [DAC_W-1:0]  code;
    } frame_t;

    // Preset value chosen by the preset select pin
    function automatic logic [DAC_W-1:0] preset_code(input logic half);
        return half ? {1'b1, {(DAC_W-1){1'b0}}} : '0;
    endfunction

endpackage

// File: rtl/dd_sync.sv
module dd_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= RST_VAL;
            else     stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dd_serial_rx.sv
module dd_serial_rx
    import dual_dac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n_s,
    input  logic   sclk_s,
    input  logic   sdi_s,
    output logic   commit,
    output frame_t word
);
    logic               sclk_d;
    logic               cs_d;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               sclk_rise;
    logic               cs_fall;
    logic               cs_rise;
    logic               full;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign cs_fall   = ~cs_n_s & cs_d;
    assign cs_rise   = cs_n_s & ~cs_d;
    assign full      = (cnt == CNT_W'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
            shreg  <= '0;
            cnt    <= '0;
            commit <= 1'b0;
            word   <= '0;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
            commit <= cs_rise & full;
            if (cs_rise) word <= frame_t'(shreg);
            if (cs_fall) begin
                cnt <= '0;
            end else if (!cs_n_s && sclk_rise) begin
                shreg <= {shreg[FRAME_W-2:0], sdi_s};
                if (!full) cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dd_chan_bank.sv
module dd_chan_bank
    import dual_dac_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_n,
    input  logic                    half_sel,
    input  logic                    commit,
    input  frame_t                  word,
    input  logic                    load_act,
    output logic [NUM_CH*DAC_W-1:0] inp_flat,
    output logic [NUM_CH*DAC_W-1:0] dac_flat
);
    logic [DAC_W-1:0] preset;
    assign preset = preset_code(half_sel);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [DAC_W-1:0] inp_q;
        logic [DAC_W-1:0] dac_q;

        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)                    inp_q <= preset;
            else if (rst)                  inp_q <= preset;
            else if (commit && word.sel[i]) inp_q <= word.code;
        end

        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)        dac_q <= preset;
            else if (rst)      dac_q <= preset;
            else if (load_act) dac_q <= inp_q;
        end

        assign inp_flat[i*DAC_W +: DAC_W] = inp_q;
        assign dac_flat[i*DAC_W +: DAC_W] = dac_q;
    end
endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
    import dual_dac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_n,
    input  logic                    half_sel,
    input  logic                    cs_n,
    input  logic                    sclk,
    input  logic                    sdi,
    input  logic                    load_n,
    output logic [NUM_CH*DAC_W-1:0] dac_code
);
    localparam int NPIN = 4;

    logic [NPIN-1:0]            pins_s;
    logic                       load_hold;
    logic                       commit;
    frame_t                     word;
    logic [NUM_CH*DAC_W-1:0]    inp_flat;

    // order: load_n, cs_n, sclk, sdi; idle strobe and select high
    dd_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({load_n, cs_n, sclk, sdi}),
        .q   (pins_s)
    );

    assign load_hold = pins_s[3];

    dd_serial_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (pins_s[2]),
        .sclk_s (pins_s[1]),
        .sdi_s  (pins_s[0]),
        .commit (commit),
        .word   (word)
    );

    dd_chan_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr_n    (clr_n),
        .half_sel (half_sel),
        .commit   (commit),
        .word     (word),
        .load_act (~load_hold),
        .inp_flat (inp_flat),
        .dac_flat (dac_code)
    );
endmodule

module dual_dac_regs_chk
    import dual_dac_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    clr_n,
    input logic                    half_sel,
    input logic                    load_hold,
    input logic                    commit,
    input logic [NUM_CH*DAC_W-1:0] inp_flat,
    input logic [NUM_CH*DAC_W-1:0] dac_code
);
    // R7
    clr_preset_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> dac_code == {NUM_CH{preset_code(half_sel)}});

    // R8
    por_preset_chk: assert property (@(posedge clk) disable iff (!clr_n)
        rst |=> dac_code == {NUM_CH{preset_code($past(half_sel))}});

    // R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        load_hold |=> $stable(dac_code));

    // R5
    inp_quiet_chk: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !commit |=> $stable(inp_flat));

    // R3
    single_commit_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

bind dual_dac_regs dual_dac_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .half_sel  (half_sel),
    .load_hold (load_hold),
    .commit    (commit),
    .inp_flat  (inp_flat),
    .dac_code  (dac_code)
);

// File: tb/dual_dac_regs_test.sv
module dual_dac_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        half_sel = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        load_n = 1'b1;
    logic [27:0] dac_code;

    int checks = 0;
    int failures = 0;
    logic [13:0] exp_inp [2];
    logic [13:0] exp_dac [2];

    always #10 clk = ~clk;

    dual_dac_regs uut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .half_sel(half_sel),
        .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .load_n(load_n),
        .dac_code(dac_code)
    );

    function automatic logic [13:0] pre_val(input logic h);
        return h ? 14'h2000 : 14'h0000;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req);
        logic [27:0] exp = {exp_dac[1], exp_dac[0]};
        checks++;
        if (dac_code !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, dac_code, exp);
        end
    endtask

    task automatic model_preset();
        for (int i = 0; i < 2; i++) begin
            exp_inp[i] = pre_val(half_sel);
            exp_dac[i] = pre_val(half_sel);
        end
    endtask

    // Send nbits of val, MSB first; update model per R1/R3/R4/R5/R6
    task automatic send_frame(input int nbits, input logic [31:0] val, input bit sclk_high_cs = 0);
        @(negedge clk);
        cs_n = sclk_high_cs;
        wait_clk(3);
        for (int b = nbits - 1; b >= 0; b--) begin
            sdi = val[b];
            wait_clk(2);
            sclk = 1'b1;
            wait_clk(2);
            sclk = 1'b0;
        end
        wait_clk(2);
        cs_n = 1'b1;
        wait_clk(10);
        if (!sclk_high_cs && nbits >= 16 && clr_n) begin
            for (int i = 0; i < 2; i++)
                if (val[14+i]) exp_inp[i] = val[13:0];
        end
        if (!load_n && clr_n) begin
            exp_dac[0] = exp_inp[0];
            exp_dac[1] = exp_inp[1];
        end
    endtask

    task automatic set_load(input logic v);
        @(negedge clk);
        load_n = v;
        wait_clk(6);
        if (!v) begin
            exp_dac[0] = exp_inp[0];
            exp_dac[1] = exp_inp[1];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_preset();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        check("R8 R9 power-on zero preset");

        // R6 hold while strobe high, then transparent
        send_frame(16, {2'b01, 14'h1234});
        check("R6 strobe high holds");
        set_load(1'b0);
        check("R5 R6 mask 01 to channel A");

        // R1 R3 R5 random frames of 16 or 24 bits
        for (int n = 0; n < 24; n++) begin
            logic [31:0] v = $urandom();
            int len = ($urandom() % 2 == 0) ? 16 : 24;
            send_frame(len, v);
            check("R1 R3 R5 random frame");
        end

        // R4 short frame ignored
        send_frame(10, 32'h3FF);
        check("R4 short frame");
        send_frame(15, 32'h7FFF);
        check("R4 15-bit frame");

        // R2 clocking with chip select high
        send_frame(16, {2'b11, 14'h0F0F}, 1);
        check("R2 cs high clocking ignored");

        // R3 24-bit frame keeps last 16 bits: mask 10 only
        send_frame(24, {8'hC3, 2'b10, 14'h0765});
        check("R3 last 16 of 24");

        // R5 mask 11 behind held strobe
        set_load(1'b1);
        send_frame(16, {2'b11, 14'h2AAA});
        check("R6 hold with both staged");
        set_load(1'b0);
        check("R5 mask 11 both channels");
        send_frame(16, {2'b00, 14'h1111});
        check("R5 mask 00 no channel");

        // R7 asynchronous clear with half scale
        @(negedge clk);
        half_sel = 1'b1;
        #3 clr_n = 1'b0;
        #2;
        model_preset();
        check("R7 R9 async clear half scale");
        send_frame(16, {2'b11, 14'h3FFF});
        check("R7 clear overrides commit");
        @(negedge clk);
        clr_n = 1'b1;
        wait_clk(6);
        check("R7 inputs preset after clear");

        // R9 clear with zero select
        @(negedge clk);
        half_sel = 1'b0;
        clr_n = 1'b0;
        wait_clk(2);
        model_preset();
        check("R9 clear zero scale");
        clr_n = 1'b1;
        wait_clk(2);

        // R8 power-on reset with half scale
        half_sel = 1'b1;
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        model_preset();
        wait_clk(2);
        check("R8 reset half scale");
        send_frame(16, {2'b00, 14'h0001});
        check("R8 preset kept without valid load");
        send_frame(16, {2'b10, 14'h0042});
        check("R5 mask 10 channel B after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule